// File: doc/BRIEF.md
# Memory-Driven Integer Matrix Product Engine

The engine computes C = A x B for two square matrices of signed 32-bit integers. A, B and C sit in three external single-port memories, and the engine drives the address and enable pins of all three memories itself. For every result element it reads one element of A and one element of B per cycle. It accumulates the products in a single multiply-accumulate stage, then writes the finished element to C with one write strobe.

The core is started by a one-cycle request while it is idle. It then runs for one pass over the whole product without any further control. It tells the host that it has finished with a pair of one-cycle pulses. Elements are stored row-major, so element (r, c) of a matrix of side DIM is at address r*DIM + c. DIM defaults to 16 and must be a power of two. A synchronous reset aborts a pass at any point.

Top module: `mat_mult_mem`

## Requirements
- R1: While `rst_i` is high, and in the cycle after it, `idle_o` is 1 and `done_o`, `ready_o`, `a_ce`, `b_ce`, `c_ce` and `c_we` are all 0.
- R2: A high `start_i` seen at a clock edge while `idle_o` is 1 starts a pass. From the next cycle until the `done_o` cycle, `idle_o` is 0.
- R3: A pass issues exactly DIM^3 reads (4096 for DIM=16), one per cycle. In each read `a_ce` and `b_ce` are both 1. Result row r is the outermost loop, result column c is the middle loop and the inner index k runs fastest. For each step, `a_addr` = r*DIM+k and `b_addr` = k*DIM+c.
- R4: Read data is taken one cycle after the address and enable are presented, and each product pairs the two operands fetched in the same cycle.
- R5: Each result is the sum over k of A[r][k]*B[k][c] in two's complement, keeping the low 32 bits. Overflow wraps silently.
- R6: The sum starts from zero for every result element, including the first element of a second pass run without a reset.
- R7: A pass makes exactly DIM^2 writes (256), each with `c_ce` and `c_we` both 1. `c_we` is never 1 without `c_ce`. Write addresses run 0, 1, 2, ... in row-major order.
- R8: `done_o` and `ready_o` are 1 together for exactly one cycle per pass, in the cycle directly after the last write.
- R9: `start_i` raised while a pass is running has no effect: the read sequence, the writes and the single completion pulse are unchanged.
- R10: `rst_i` during a pass stops all memory activity at once. No write follows, and a later pass runs correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Pass request, taken only while idle |
| done_o | output | 1 | One-cycle completion pulse |
| idle_o | output | 1 | High when no pass is running |
| ready_o | output | 1 | One-cycle pulse, can accept a new start |
| a_addr | output | 8 | Address into matrix A |
| a_ce | output | 1 | Read enable for A |
| a_rdata | input | 32 | Data from A, one cycle after the read |
| b_addr | output | 8 | Address into matrix B |
| b_ce | output | 1 | Read enable for B |
| b_rdata | input | 32 | Data from B, one cycle after the read |
| c_addr | output | 8 | Address into matrix C |
| c_ce | output | 1 | Enable for C |
| c_we | output | 1 | Write strobe for C |
| c_wdata | output | 32 | Result element written to C |

## Verification
Two things happen on the same clock edge inside a pass. The finished sum of one element is captured for its write, and the accumulator is reloaded with the first product of the next element. Every element boundary provokes this, because reads run back to back across elements. It is judged by comparing all 256 stored results with a model in the bench, using data where a missed clear or a stolen product changes the answer, across back-to-back passes. A start request arriving during the completion cycle is also used, to check that a new pass begins cleanly there.

// File: rtl/mat_mult_mem.sv
module mat_mult_mem #(
  parameter int DIM = 16,
  parameter int DW  = 32
) (
  input  logic                         clk,
  input  logic                         rst_i,
  input  logic                         start_i,
  output logic                         done_o,
  output logic                         idle_o,
  output logic                         ready_o,
  output logic [2*$clog2(DIM)-1:0]     a_addr,
  output logic                         a_ce,
  input  logic [DW-1:0]                a_rdata,
  output logic [2*$clog2(DIM)-1:0]     b_addr,
  output logic                         b_ce,
  input  logic [DW-1:0]                b_rdata,
  output logic [2*$clog2(DIM)-1:0]     c_addr,
  output logic                         c_ce,
  output logic                         c_we,
  output logic [DW-1:0]                c_wdata
);
  localparam int IW = $clog2(DIM);
  localparam int AW = 2 * IW;
  localparam logic [IW-1:0] TOP = IW'(DIM - 1);

  logic          busy, issuing;
  logic [IW-1:0] ri, cj, kk;
  logic          last_k, last_j, last_i;

  logic          rd_vld, rd_first, rd_last, rd_fin;
  logic [AW-1:0] rd_dst;
  logic [DW-1:0] acc, sum;
  logic          c_fin;

  assign last_k = (kk == TOP);
  assign last_j = (cj == TOP);
  assign last_i = (ri == TOP);

  assign a_ce   = issuing;
  assign b_ce   = issuing;
  assign a_addr = {ri, kk};
  assign b_addr = {kk, cj};
  assign idle_o  = !busy;
  assign ready_o = done_o;

  assign sum = (rd_first ? '0 : acc) + DW'(a_rdata * b_rdata);

  always_ff @(posedge clk) begin
    if (rst_i) begin
      busy    <= 1'b0;
      issuing <= 1'b0;
      ri      <= '0;
      cj      <= '0;
      kk      <= '0;
    end else begin
      if (start_i && !busy) begin
        busy    <= 1'b1;
        issuing <= 1'b1;
        ri      <= '0;
        cj      <= '0;
        kk      <= '0;
      end else if (issuing) begin
        kk <= kk + 1'b1;
        if (last_k) begin
          cj <= cj + 1'b1;
          if (last_j) begin
            ri <= ri + 1'b1;
            if (last_i) issuing <= 1'b0;
          end
        end
      end
      if (c_ce && c_fin) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_i) begin
      rd_vld <= 1'b0;
      c_ce   <= 1'b0;
      c_we   <= 1'b0;
      c_fin  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      rd_vld <= issuing;
      c_ce   <= rd_vld && rd_last;
      c_we   <= rd_vld && rd_last;
      c_fin  <= rd_vld && rd_last && rd_fin;
      done_o <= c_ce && c_fin;
    end
  end

  always_ff @(posedge clk) begin
    rd_first <= (kk == '0);
    rd_last  <= last_k;
    rd_fin   <= last_i && last_j && last_k;
    rd_dst   <= {ri, cj};
    if (rd_vld) acc <= sum;
    if (rd_vld && rd_last) begin
      c_addr  <= rd_dst;
      c_wdata <= sum;
    end
  end
endmodule

// File: rtl/mat_mult_mem_chk.sv
module mat_mult_mem_chk #(
  parameter int DIM = 16
) (
  input logic                     clk,
  input logic                     rst_i,
  input logic                     done_o,
  input logic                     idle_o,
  input logic                     ready_o,
  input logic [2*$clog2(DIM)-1:0] a_addr,
  input logic                     a_ce,
  input logic                     b_ce,
  input logic                     c_ce,
  input logic                     c_we
);
  localparam int IW = $clog2(DIM);
  localparam int AW = 2 * IW;

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst_i |=> (idle_o && !a_ce && !c_ce && !done_o));

  p_reads_mean_busy_r2: assert property (@(posedge clk) disable iff (rst_i)
    a_ce |-> !idle_o);

  p_ce_pair_r3: assert property (@(posedge clk) disable iff (rst_i)
    (a_ce || b_ce) |-> (a_ce && b_ce));

  p_inner_step_r3: assert property (@(posedge clk) disable iff (rst_i)
    (a_ce && $past(a_ce) && a_addr[IW-1:0] != '0) |->
      (a_addr == AW'($past(a_addr) + 1'b1)));

  p_we_with_ce_r7: assert property (@(posedge clk) disable iff (rst_i)
    c_we |-> c_ce);

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst_i)
    done_o |=> !done_o);

  p_done_after_write_r8: assert property (@(posedge clk) disable iff (rst_i)
    done_o |-> ($past(c_we) && ready_o));
endmodule

bind mat_mult_mem mat_mult_mem_chk #(.DIM(DIM)) u_chk (
  .clk(clk), .rst_i(rst_i), .done_o(done_o), .idle_o(idle_o),
  .ready_o(ready_o), .a_addr(a_addr), .a_ce(a_ce), .b_ce(b_ce),
  .c_ce(c_ce), .c_we(c_we)
);

// File: tb/sim_mat_mult_mem.sv
`timescale 1ns/1ps
module sim_mat_mult_mem;
  localparam int N = 16;
  localparam int E = N * N;

  logic clk = 0, rst_i = 1, start_i = 0;
  logic done_o, idle_o, ready_o, a_ce, b_ce, c_ce, c_we;
  logic [7:0] a_addr, b_addr, c_addr;
  logic [31:0] a_rdata, b_rdata, c_wdata;

  logic [31:0] ma [E];
  logic [31:0] mb [E];
  logic [31:0] mc [E];
  logic [31:0] ref_c [E];

  int n_chk = 0, n_err = 0, cyc = 0;
  int rd_idx, rd_err, wr_cnt, wr_err, done_cnt, dgap_err, last_wr;
  int seed = 7;

  always #10 clk = ~clk;

  mat_mult_mem u0 (
    .clk(clk), .rst_i(rst_i), .start_i(start_i), .done_o(done_o),
    .idle_o(idle_o), .ready_o(ready_o),
    .a_addr(a_addr), .a_ce(a_ce), .a_rdata(a_rdata),
    .b_addr(b_addr), .b_ce(b_ce), .b_rdata(b_rdata),
    .c_addr(c_addr), .c_ce(c_ce), .c_we(c_we), .c_wdata(c_wdata)
  );

  always @(posedge clk) begin
    if (a_ce) a_rdata <= ma[a_addr];
    if (b_ce) b_rdata <= mb[b_addr];
    if (c_ce && c_we) mc[c_addr] <= c_wdata;
  end

  always @(negedge clk) begin
    cyc++;
    if (!rst_i) begin
      if (a_ce || b_ce) begin
        if (!(a_ce && b_ce)) rd_err++;
        if (a_addr != 8'(((rd_idx >> 8) & 15) * N + (rd_idx & 15))) rd_err++;
        if (b_addr != 8'((rd_idx & 15) * N + ((rd_idx >> 4) & 15))) rd_err++;
        rd_idx++;
      end
      if (c_we) begin
        if (!c_ce || c_addr != 8'(wr_cnt)) wr_err++;
        wr_cnt++;
        last_wr = cyc;
      end
      if (done_o) begin
        done_cnt++;
        if (cyc != last_wr + 1 || ready_o !== 1'b1) dgap_err++;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 1103515245 + 12345;
    return 32'(seed);
  endfunction

  task automatic clear_mon();
    rd_idx = 0; rd_err = 0; wr_cnt = 0; wr_err = 0;
    done_cnt = 0; dgap_err = 0; last_wr = -10;
  endtask

  task automatic fill(int mode);
    for (int i = 0; i < E; i++) begin
      case (mode)
        0: begin ma[i] = ((i / N) == (i % N)) ? 32'd1 : 32'd0; mb[i] = rnd(); end
        1: begin ma[i] = 32'($signed(rnd()) >>> 24); mb[i] = 32'($signed(rnd()) >>> 22); end
        default: begin ma[i] = 32'h7fff_fff0 ^ 32'(i); mb[i] = 32'h8000_0003 + 32'(i * 7); end
      endcase
      mc[i] = 32'hdead_beef;
    end
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        logic [31:0] s = 0;
        for (int k = 0; k < N; k++) s = s + ma[r*N+k] * mb[k*N+c];
        ref_c[r*N+c] = s;
      end
  endtask

  task automatic run_pass(string tag, int mode, bit poke_busy);
    int mism = 0;
    int t = 0;
    fill(mode);
    clear_mon();
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
    chk({tag, " R2 idle low after start"}, 32'(idle_o), 0);
    while (done_cnt == 0 && t < 6000) begin
      @(negedge clk);
      t++;
      if (poke_busy && (t == 1000 || t == 4095)) start_i = 1;
      else start_i = 0;
    end
    start_i = 0;
    if (done_cnt == 0) chk({tag, " R8 completion timeout"}, 0, 1);
    repeat (3) @(negedge clk);
    for (int i = 0; i < E; i++) if (mc[i] !== ref_c[i]) begin
      if (mism == 0) $display("FAIL %s R5 element %0d actual=%0h expected=%0h", tag, i, mc[i], ref_c[i]);
      mism++;
    end
    chk({tag, " R4 R5 R6 mismatching results"}, 32'(mism), 0);
    chk({tag, " R3 read count"}, 32'(rd_idx), 32'(N*N*N));
    chk({tag, " R3 read order"}, 32'(rd_err), 0);
    chk({tag, " R7 write count"}, 32'(wr_cnt), 32'(E));
    chk({tag, " R7 write order"}, 32'(wr_err), 0);
    chk({tag, " R8 done pulses"}, 32'(done_cnt), 1);
    chk({tag, " R8 done placement"}, 32'(dgap_err), 0);
    chk({tag, " R2 idle after pass"}, 32'(idle_o), 1);
  endtask

  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    chk("R1 idle in reset", 32'(idle_o), 1);
    rst_i = 0;
    @(negedge clk);
    chk("R1 enables off", 32'({a_ce, b_ce, c_ce, c_we}), 0);
    chk("R1 pulses off", 32'({done_o, ready_o}), 0);
  endtask

  task automatic t_abort();
    int w;
    fill(1);
    clear_mon();
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
    repeat (700) @(negedge clk);
    rst_i = 1;
    @(negedge clk);
    chk("R10 idle after abort", 32'(idle_o), 1);
    chk("R10 enables after abort", 32'({a_ce, b_ce, c_ce, c_we}), 0);
    rst_i = 0;
    w = wr_cnt;
    repeat (20) @(negedge clk);
    chk("R10 no writes after abort", 32'(wr_cnt), 32'(w));
    chk("R10 no done after abort", 32'(done_cnt), 0);
  endtask

  task automatic t_restart_in_done();
    int t = 0;
    fill(1);
    clear_mon();
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
    while (done_cnt == 0 && t < 6000) begin @(negedge clk); t++; end
    start_i = 1;
    @(negedge clk) start_i = 0;
    chk("R2 start in done cycle accepted", 32'(idle_o), 0);
    clear_mon();
    rd_idx = 1;
    t = 0;
    while (done_cnt == 0 && t < 6000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk("R6 second pass result element 0", mc[0], ref_c[0]);
    chk("R6 second pass result last element", mc[E-1], ref_c[E-1]);
    chk("R8 second pass done", 32'(done_cnt), 1);
  endtask

  initial begin
    t_reset_state();
    run_pass("identity", 0, 0);
    run_pass("signed", 1, 0);
    run_pass("wrap", 2, 0);
    run_pass("R9 busy start", 1, 1);
    t_abort();
    run_pass("R10 after abort", 2, 0);
    t_restart_in_done();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(20ns * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule